// File: doc/BRIEF.md
# Double-Buffered Audio DMA Channel Pair

This block moves 32-bit audio words between system memory and a codec over two independent channels. Playback fetches words from memory and presents them on an outgoing valid/ready sample stream. Capture takes words from an incoming sample stream and stores them to memory. Each channel owns an active descriptor (address and byte count) and a staged descriptor that software may load while the active one is still running. The engine swaps the staged descriptor in at the end of a block, so consecutive buffers play or record without a gap.

Software sees nine 32-bit registers placed from a configurable byte offset in its register window. They hold a shared control/status word and the four descriptor registers of each channel. Interrupt flags in the control/status word are cleared by writing ones to them, so software can write back the value it read. A pause request never cuts a block short. The channel finishes the block in progress and then parks. A block that ends with nothing staged also parks the channel and raises an error flag.

Top module: `audio_dma_pair`

## Requirements
- R1: The registers sit at byte addresses BASE+4*k for k = 0..8, where BASE defaults to 16. The assignments are: k=0 control/status; k=1..4 playback active address, active count, staged address, staged count; k=5..8 the same four for capture. The active registers are read-only. Addresses outside the window read as 0, and writes to them change nothing.
- R2: Layout of the control/status word. Bit 0 is the global interrupt enable and bit 1 the error interrupt enable. Playback owns bits 2 go, 3 pause, 4 block interrupt enable and 5 stop interrupt enable; capture owns bits 6 to 9 in the same order. Read-only status bits are 12 playback staged-free, 13 playback stopped, 14 capture staged-free and 15 capture stopped. The flag bits are 16 playback block, 17 playback stop, 18 playback error, 19 capture block, 20 capture stop and 21 capture error. After reset the word reads 0x0000F000 and irq is 0.
- R3: A write to a channel's staged count marks the staged pair valid, and its staged-free bit reads 0 until the pair is taken into the active registers.
- R4: When go is 1, pause is 0, the channel is stopped and a staged pair is valid, the pair becomes active and staged-free returns to 1. This first promotion raises no flag.
- R5: Each word moved advances the active address by 4 and reduces the active count by 4. A count below 4 is treated as one last word. Playback words leave on the sample stream in address order. Capture stores each accepted sample at the active address.
- R6: When the active count is 0 and go=1, pause=0 and a staged pair is valid, the pair is promoted and the block flag is set. A block loaded with count 0 ends one cycle after it becomes active.
- R7: Setting pause does not abort the block in progress. At its end the channel stops, sets its stopped bit and stop flag, and leaves any staged pair loaded.
- R8: A block that ends with go=1, pause=0 and no valid staged pair stops the channel, sets its error flag and clears its go bit.
- R9: A control/status write with 1 in a flag bit clears that flag, and 0 leaves it as it was.
- R10: irq is bit 0 ANDed with the OR of the flags whose enables are set. The block flags are enabled by bits 4/8, the stop flags by bits 5/9 and the error flags by bit 1. irq falls in the cycle after the write that clears the last enabled flag.
- R11: The memory side keeps one request outstanding. mem_req, mem_addr and mem_we hold until mem_ack. A pending capture write wins over a playback read.
- R12: Once pb_valid is high, it stays high with pb_data unchanged until pb_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = capture write, 0 = playback read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| pb_valid | output | 1 | Playback sample valid |
| pb_ready | input | 1 | Codec takes the playback sample |
| pb_data | output | 32 | Playback sample |
| cap_valid | input | 1 | Capture sample valid |
| cap_ready | output | 1 | Engine takes the capture sample |
| cap_data | input | 32 | Capture sample |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 6-bit register address with the window at byte 16, 32-bit memory addresses and 16-bit counts. Under these values every register is reachable, and blocks of one to a dozen words finish quickly. A whole pause, restart, chaining and starvation sequence therefore fits in a few hundred cycles. Random memory latency and random stream stalls put capture writes and playback reads in contention for the single memory port. Holding the playback sink back keeps a block open long enough to stage its successor, and this drives the chain, zero-length and pause orders on purpose.

// File: rtl/audio_dma_pair.sv
module audio_dma_pair #(
  parameter int REG_AW = 6,
  parameter int BASE   = 16,
  parameter int AW     = 32,
  parameter int CW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              pb_valid,
  input  logic              pb_ready,
  output logic [31:0]       pb_data,
  input  logic              cap_valid,
  output logic              cap_ready,
  input  logic [31:0]       cap_data,
  output logic              irq
);
  localparam int NREG = 9;
  localparam logic [REG_AW-1:0] BASE_A = REG_AW'(BASE);
  localparam logic [REG_AW-1:0] SPAN   = REG_AW'(4 * NREG);

  function automatic logic [CW-1:0] dec4(input logic [CW-1:0] x);
    return (x <= CW'(4)) ? '0 : x - CW'(4);
  endfunction

  logic [REG_AW-1:0] off;
  logic              hit;
  logic [31:0]       ridx;
  assign off  = reg_addr - BASE_A;
  assign hit  = (reg_addr >= BASE_A) && (off < SPAN) && (off[1:0] == 2'b00);
  assign ridx = 32'(off[REG_AW-1:2]);

  logic wr_csr, wr_pna, wr_pnc, wr_cna, wr_cnc;
  assign wr_csr = reg_we && hit && (ridx == 0);
  assign wr_pna = reg_we && hit && (ridx == 3);
  assign wr_pnc = reg_we && hit && (ridx == 4);
  assign wr_cna = reg_we && hit && (ridx == 7);
  assign wr_cnc = reg_we && hit && (ridx == 8);

  logic [9:0] ctl;
  logic [5:0] ist;

  logic          p_busy, p_nval;
  logic [AW-1:0] p_addr, p_naddr;
  logic [CW-1:0] p_cnt, p_ncnt;
  logic          c_busy, c_nval;
  logic [AW-1:0] c_addr, c_naddr;
  logic [CW-1:0] c_cnt, c_ncnt;
  logic          pbuf_v, cbuf_v;
  logic [31:0]   pbuf, cbuf;

  logic p_go, p_pause, c_go, c_pause;
  assign p_go    = ctl[2];
  assign p_pause = ctl[3];
  assign c_go    = ctl[6];
  assign c_pause = ctl[7];

  logic p_end, p_start, p_chain, p_halt, p_starve, p_prom;
  assign p_end    = p_busy && (p_cnt == '0);
  assign p_start  = !p_busy && p_go && !p_pause && p_nval;
  assign p_chain  = p_end && p_go && !p_pause && p_nval;
  assign p_halt   = p_end && (p_pause || !p_go);
  assign p_starve = p_end && p_go && !p_pause && !p_nval;
  assign p_prom   = p_start || p_chain;

  logic c_end, c_start, c_chain, c_halt, c_starve, c_prom;
  assign c_end    = c_busy && (c_cnt == '0);
  assign c_start  = !c_busy && c_go && !c_pause && c_nval;
  assign c_chain  = c_end && c_go && !c_pause && c_nval;
  assign c_halt   = c_end && (c_pause || !c_go);
  assign c_starve = c_end && c_go && !c_pause && !c_nval;
  assign c_prom   = c_start || c_chain;

  logic p_ack, c_ack, p_want;
  assign p_ack  = mem_req && mem_ack && !mem_we;
  assign c_ack  = mem_req && mem_ack && mem_we;
  assign p_want = p_busy && (p_cnt != '0) && !pbuf_v;

  logic [5:0] ist_set, ist_clr;
  assign ist_set = {c_starve, c_halt, c_chain, p_starve, p_halt, p_chain};
  assign ist_clr = wr_csr ? reg_wdata[21:16] : 6'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      ist <= '0;
    end else begin
      if (wr_csr) ctl <= reg_wdata[9:0];
      if (p_starve) ctl[2] <= 1'b0;
      if (c_starve) ctl[6] <= 1'b0;
      ist <= (ist & ~ist_clr) | ist_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_busy <= 1'b0; p_nval <= 1'b0;
      p_addr <= '0;   p_cnt  <= '0;
      p_naddr <= '0;  p_ncnt <= '0;
      pbuf_v <= 1'b0; pbuf <= '0;
    end else begin
      if (wr_pna) p_naddr <= reg_wdata[AW-1:0];
      if (wr_pnc) p_ncnt  <= reg_wdata[CW-1:0];
      if (wr_pnc) p_nval <= 1'b1;
      else if (p_prom) p_nval <= 1'b0;
      if (p_prom) begin
        p_busy <= 1'b1;
        p_addr <= p_naddr;
        p_cnt  <= p_ncnt;
      end else begin
        if (p_end) p_busy <= 1'b0;
        if (p_ack) begin
          p_addr <= p_addr + AW'(4);
          p_cnt  <= dec4(p_cnt);
        end
      end
      if (p_ack) begin
        pbuf   <= mem_rdata;
        pbuf_v <= 1'b1;
      end else if (pbuf_v && pb_ready) begin
        pbuf_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_busy <= 1'b0; c_nval <= 1'b0;
      c_addr <= '0;   c_cnt  <= '0;
      c_naddr <= '0;  c_ncnt <= '0;
      cbuf_v <= 1'b0; cbuf <= '0;
    end else begin
      if (wr_cna) c_naddr <= reg_wdata[AW-1:0];
      if (wr_cnc) c_ncnt  <= reg_wdata[CW-1:0];
      if (wr_cnc) c_nval <= 1'b1;
      else if (c_prom) c_nval <= 1'b0;
      if (c_prom) begin
        c_busy <= 1'b1;
        c_addr <= c_naddr;
        c_cnt  <= c_ncnt;
      end else begin
        if (c_end) c_busy <= 1'b0;
        if (c_ack) begin
          c_addr <= c_addr + AW'(4);
          c_cnt  <= dec4(c_cnt);
        end
      end
      if (cap_valid && cap_ready) begin
        cbuf   <= cap_data;
        cbuf_v <= 1'b1;
      end else if (c_ack) begin
        cbuf_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
    end else if (!mem_req) begin
      if (cbuf_v) begin
        mem_req <= 1'b1;
        mem_we  <= 1'b1;
      end else if (p_want) begin
        mem_req <= 1'b1;
        mem_we  <= 1'b0;
      end
    end else if (mem_ack) begin
      mem_req <= 1'b0;
    end
  end

  assign mem_addr  = mem_we ? c_addr : p_addr;
  assign mem_wdata = cbuf;
  assign pb_valid  = pbuf_v;
  assign pb_data   = pbuf;
  assign cap_ready = c_busy && (c_cnt != '0) && !cbuf_v;

  logic [5:0] ist_en;
  assign ist_en = {ctl[1], ctl[9], ctl[8], ctl[1], ctl[5], ctl[4]};
  assign irq    = ctl[0] && |(ist & ist_en);

  logic [31:0] csr;
  assign csr = {10'd0, ist, !c_busy, !c_nval, !p_busy, !p_nval, 2'd0, ctl};

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      case (ridx)
        0: reg_rdata = csr;
        1: reg_rdata = 32'(p_addr);
        2: reg_rdata = 32'(p_cnt);
        3: reg_rdata = 32'(p_naddr);
        4: reg_rdata = 32'(p_ncnt);
        5: reg_rdata = 32'(c_addr);
        6: reg_rdata = 32'(c_cnt);
        7: reg_rdata = 32'(c_naddr);
        8: reg_rdata = 32'(c_ncnt);
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/audio_dma_pair_chk.sv
module audio_dma_pair_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          pb_valid,
  input logic          pb_ready,
  input logic [31:0]   pb_data,
  input logic          p_busy,
  input logic [CW-1:0] p_cnt,
  input logic [5:0]    ist
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
  AST_PB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pb_valid && !pb_ready |=> pb_valid && $stable(pb_data)); // R12
  AST_READ_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> p_busy && (p_cnt != '0)); // R5
  AST_PAUSE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    p_busy && (p_cnt != '0) |=> p_busy); // R7
  AST_STOP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(p_busy) |-> ist[1] || ist[2]); // R8
endmodule

bind audio_dma_pair audio_dma_pair_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_we(mem_we), .mem_addr(mem_addr), .pb_valid(pb_valid),
  .pb_ready(pb_ready), .pb_data(pb_data), .p_busy(p_busy),
  .p_cnt(p_cnt), .ist(ist)
);

// File: tb/sim_audio_dma_pair.sv
`timescale 1ns/1ps
module sim_audio_dma_pair;
  localparam int REG_AW = 6;
  localparam int BASE   = 16;

  localparam logic [31:0] G = 32'h1, E = 32'h2, PGO = 32'h4, PPA = 32'h8,
    PIE = 32'h10, PSIE = 32'h20, CGO = 32'h40, CIE = 32'h100;
  localparam logic [31:0] PF = 32'h1000, PST = 32'h2000, CF = 32'h4000, CST = 32'h8000;
  localparam logic [31:0] PB = 32'h10000, PS = 32'h20000, PE = 32'h40000,
    CB = 32'h80000, CE = 32'h200000;
  localparam logic [31:0] ALLF = 32'h3F0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic pb_valid, pb_ready = 1'b0;
  logic [31:0] pb_data;
  logic cap_valid = 1'b0, cap_ready;
  logic [31:0] cap_data = 32'h0;
  logic irq;

  always #5 clk = ~clk;

  audio_dma_pair #(.REG_AW(REG_AW), .BASE(BASE), .AW(32), .CW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pb_valid(pb_valid),
    .pb_ready(pb_ready), .pb_data(pb_data), .cap_valid(cap_valid),
    .cap_ready(cap_ready), .cap_data(cap_data), .irq(irq));

  int checks = 0, fails = 0;
  bit pb_en = 1'b0, cap_en = 1'b0;
  logic [31:0] q_pexp[$];
  logic [31:0] q_caexp[$];
  logic [31:0] q_cdexp[$];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic logic [REG_AW-1:0] ra(input int k);
    return REG_AW'(BASE + 4 * k);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push_blk(input bit cap, input logic [31:0] a, input int len);
    for (int i = 0; i < (len + 3) / 4; i++) begin
      if (cap) q_caexp.push_back(a + 32'(4 * i));
      else q_pexp.push_back(a + 32'(4 * i));
    end
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((q_pexp.size() != 0 || q_caexp.size() != 0) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, tag, 32'(q_pexp.size() + q_caexp.size()), 0);
    repeat (6) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && ($urandom % 3 == 0)) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        if (q_caexp.size() == 0 || q_cdexp.size() == 0) begin
          chk(1'b0, "R5 unexpected capture write", mem_addr, 0);
        end else begin
          logic [31:0] ea, ed;
          ea = q_caexp.pop_front();
          ed = q_cdexp.pop_front();
          chk(mem_addr == ea, "R5 capture address", mem_addr, ea);
          chk(mem_wdata == ed, "R5 capture data", mem_wdata, ed);
        end
      end else begin
        mem_rdata = pat(mem_addr);
      end
    end
  end

  always @(negedge clk) begin
    pb_ready = pb_en && ($urandom % 4 != 0);
    if (pb_valid && pb_ready) begin
      if (q_pexp.size() == 0) begin
        chk(1'b0, "R5 unexpected playback word", pb_data, 0);
      end else begin
        logic [31:0] ea;
        ea = q_pexp.pop_front();
        chk(pb_data == pat(ea), "R5 playback word order", pb_data, pat(ea));
      end
    end
  end

  always @(negedge clk) begin
    cap_valid = cap_en && ($urandom % 2 == 0);
    if (cap_valid && cap_ready) begin
      q_cdexp.push_back(cap_data);
    end
  end
  always @(posedge clk) if (cap_valid && cap_ready) cap_data <= $urandom;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(ra(0), v);
    chk(v == 32'h0000F000, "R2 reset status word", v, 32'h0000F000);
    chk(irq == 1'b0, "R2 reset irq", {31'd0, irq}, 0);
    chk(mem_req == 1'b0 && pb_valid == 1'b0, "R2 reset outputs", {30'd0, mem_req, pb_valid}, 0);

    wr(ra(3), 32'h0000_AB00);
    rd(ra(3), v);
    chk(v == 32'h0000_AB00, "R1 staged address readback", v, 32'h0000_AB00);
    wr(ra(1), 32'h0000_1234);
    rd(ra(1), v);
    chk(v == 32'h0, "R1 active address read-only", v, 0);
    wr(REG_AW'(4), 32'h3FF);
    rd(ra(0), v);
    chk(v == 32'h0000F000, "R1 write outside window ignored", v, 32'h0000F000);
    rd(REG_AW'(8), v);
    chk(v == 32'h0, "R1 read outside window", v, 0);

    pb_en = 1'b0;
    wr(ra(3), 32'h1000);
    wr(ra(4), 16);
    rd(ra(0), v);
    chk((v & PF) == 0, "R3 staged-free clears on load", v, v & ~PF);
    push_blk(1'b0, 32'h1000, 16);
    wr(ra(0), G | E | PGO | PIE);
    repeat (3) @(negedge clk);
    rd(ra(0), v);
    chk((v & (PF | PST | ALLF)) == PF, "R4 start promotes without flag", v & (PF | PST | ALLF), PF);
    chk(irq == 1'b0, "R4 no irq on start", {31'd0, irq}, 0);
    wr(ra(3), 32'h2000);
    wr(ra(4), 8);
    push_blk(1'b0, 32'h2000, 8);
    pb_en = 1'b1;
    drain("R6 chained playback finishes");
    rd(ra(0), v);
    chk((v & (PB | PS | PE | PGO | PST)) == (PB | PE | PST), "R8 chain then starve flags",
        v & (PB | PS | PE | PGO | PST), PB | PE | PST);
    chk(irq == 1'b1, "R10 irq with enabled flags", {31'd0, irq}, 1);
    rd(ra(1), v);
    chk(v == 32'h2008, "R5 active address advanced", v, 32'h2008);
    rd(ra(2), v);
    chk(v == 32'h0, "R5 active count reaches zero", v, 0);

    wr(ra(0), E | PIE);
    chk(irq == 1'b0, "R10 global enable gates irq", {31'd0, irq}, 0);
    rd(ra(0), v);
    chk((v & ALLF) == (PB | PE), "R9 zero in flag bits keeps flags", v & ALLF, PB | PE);
    wr(ra(0), G | E | PIE | PB);
    rd(ra(0), v);
    chk((v & ALLF) == PE, "R9 one clears only that flag", v & ALLF, PE);
    chk(irq == 1'b1, "R10 error flag keeps irq", {31'd0, irq}, 1);
    wr(ra(0), G | E | PIE | PE);
    chk(irq == 1'b0, "R10 irq falls after clear", {31'd0, irq}, 0);

    pb_en = 1'b0;
    wr(ra(3), 32'h3000);
    wr(ra(4), 32);
    push_blk(1'b0, 32'h3000, 32);
    wr(ra(0), G | E | PGO | PIE | PSIE);
    repeat (3) @(negedge clk);
    wr(ra(3), 32'h4000);
    wr(ra(4), 8);
    wr(ra(0), G | E | PGO | PPA | PIE | PSIE);
    pb_en = 1'b1;
    drain("R7 paused block drains");
    rd(ra(0), v);
    chk((v & (PB | PS | PE | PF | PST)) == (PS | PST), "R7 pause stops with stop flag",
        v & (PB | PS | PE | PF | PST), PS | PST);
    chk(irq == 1'b1, "R10 stop flag raises irq", {31'd0, irq}, 1);
    push_blk(1'b0, 32'h4000, 8);
    wr(ra(0), G | E | PGO | PIE | PSIE | PS);
    drain("R4 restart after pause");
    rd(ra(0), v);
    chk((v & (PB | PS | PE | PGO)) == PE, "R8 restarted block starves",
        v & (PB | PS | PE | PGO), PE);
    wr(ra(0), ALLF);

    pb_en = 1'b0;
    wr(ra(3), 32'h6000);
    wr(ra(4), 8);
    push_blk(1'b0, 32'h6000, 8);
    wr(ra(0), G | E | PGO | PIE);
    repeat (3) @(negedge clk);
    wr(ra(3), 32'h5000);
    wr(ra(4), 0);
    pb_en = 1'b1;
    drain("R6 zero-length chain");
    rd(ra(0), v);
    chk((v & (PB | PS | PE)) == (PB | PE), "R6 zero block ends at once", v & (PB | PS | PE), PB | PE);
    rd(ra(1), v);
    chk(v == 32'h5000, "R6 zero block moves nothing", v, 32'h5000);
    wr(ra(0), ALLF);

    wr(ra(7), 32'h8000);
    wr(ra(8), 40);
    push_blk(1'b1, 32'h8000, 40);
    wr(ra(3), 32'h9000);
    wr(ra(4), 40);
    push_blk(1'b0, 32'h9000, 40);
    cap_en = 1'b1;
    pb_en = 1'b1;
    wr(ra(0), G | E | PGO | CGO | PIE | CIE);
    drain("R11 shared memory port");
    rd(ra(0), v);
    chk((v & (CE | PE | CGO | PGO | CST | PST)) == (CE | PE | CST | PST), "R11 both channels complete",
        v & (CE | PE | CGO | PGO | CST | PST), CE | PE | CST | PST);
    rd(ra(5), v);
    chk(v == 32'h8028, "R5 capture address advanced", v, 32'h8028);
    wr(ra(0), ALLF);

    for (int it = 0; it < 4; it++) begin
      int l1, l2, l3, l4;
      logic [31:0] a1, a2, a3, a4;
      l1 = 4 * (2 + int'($urandom % 10));
      l2 = 4 * (1 + int'($urandom % 10));
      l3 = 4 * (1 + int'($urandom % 10));
      l4 = 4 * (1 + int'($urandom % 10));
      a1 = 32'h10000 + 32'(it * 32'h1000);
      a2 = a1 + 32'h100;
      a3 = a1 + 32'h200;
      a4 = a1 + 32'h300;
      pb_en = 1'b0;
      cap_en = 1'b0;
      wr(ra(3), a1); wr(ra(4), 32'(l1)); push_blk(1'b0, a1, l1);
      wr(ra(7), a3); wr(ra(8), 32'(l3)); push_blk(1'b1, a3, l3);
      wr(ra(0), G | E | PGO | CGO | PIE | CIE);
      repeat (3) @(negedge clk);
      wr(ra(3), a2); wr(ra(4), 32'(l2)); push_blk(1'b0, a2, l2);
      wr(ra(7), a4); wr(ra(8), 32'(l4)); push_blk(1'b1, a4, l4);
      pb_en = 1'b1;
      cap_en = 1'b1;
      drain("R6 random chained blocks");
      rd(ra(0), v);
      chk((v & ALLF) == (PB | PE | CB | CE), "R6 random chain flags", v & ALLF, PB | PE | CB | CE);
      rd(ra(1), v);
      chk(v == a2 + 32'(l2), "R5 random playback end address", v, a2 + 32'(l2));
      rd(ra(5), v);
      chk(v == a4 + 32'(l4), "R5 random capture end address", v, a4 + 32'(l4));
      wr(ra(0), ALLF);
    end
    cap_en = 1'b0;
    pb_en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule